// File: doc/BRIEF.md
# Strobe/Busy Parallel Byte Responder

This block sits on the peripheral side of an 8-bit bidirectional parallel link. The host software polls and toggles a single handshake line, which acts as a data strobe in one direction and as a read acknowledge in the other. The block answers on a BUSY line. Bytes from the host arrive at local logic as a one-cycle valid pulse. Local logic offers a byte to the host through a request input, which the block accepts only when it shows ready.

The handshake line from the host is asynchronous, so it passes through a two-stage synchronizer before the control logic sees it. Every phase that waits on the host has a watchdog, and its length is set in clock cycles by an input. When a phase stalls past that length, the block abandons the exchange. It raises a sticky error flag, releases the bus, drives BUSY high and goes back to idle. The peripheral drives the shared data bus only while a byte of its own is waiting for the host to read it.

Top module: `strobe_busy_responder`

## Requirements
- R1: After reset, BUSY is high (ready), the bus driver is off, rxValid and errFlag are low, and txReady is high while the handshake line is low.
- R2: A rising edge of the host handshake line is seen after two synchronizer flops. On the third rising clock edge after the line goes high, the byte on the bus is captured, rxValid is high for exactly one cycle with that byte, and BUSY goes low.
- R3: While BUSY is low after a capture, BUSY returns high once the synchronized handshake line is low again, and the block is then idle.
- R4: A transmit request is taken only while txReady is high, meaning the block is idle and the synchronized handshake line is low. The byte then appears on the bus with the driver enabled, and BUSY goes low.
- R5: When the synchronized handshake line goes high during an outbound byte, the driver turns off and BUSY goes high. txReady stays low until the line is low again.
- R6: If a handshake edge and a transmit request arrive together, the inbound capture wins and the transmit request is not taken.
- R7: If a waiting phase sees no progress for tmoLimit+1 cycles, errFlag is set, the driver turns off, BUSY goes high, and the block returns to idle.
- R8: After a timeout that leaves the handshake line high, no byte is captured until the line falls and rises again.
- R9: A transmit request made while txReady is low is ignored. The bus stays undriven and the byte is never presented.
- R10: errFlag stays high until reset, even while later transfers complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmoLimit | input | 24 | Timeout length in cycles for each waiting phase |
| hostStrobe | input | 1 | Asynchronous host handshake line (strobe or acknowledge) |
| busyOut | output | 1 | BUSY to host, high = ready |
| busDataIn | input | 8 | Bus value seen from the host |
| busDataOut | output | 8 | Byte driven toward the host |
| busDataOe | output | 1 | Bus driver enable |
| rxValid | output | 1 | One-cycle pulse, a byte was received |
| rxByte | output | 8 | Received byte |
| txValid | input | 1 | Local request to send txByte |
| txByte | input | 8 | Byte to send to the host |
| txReady | output | 1 | A transmit request would be taken this cycle |
| errFlag | output | 1 | Sticky timeout flag |

## Verification
Some relationships are checked by assertions on every cycle. These are: the bus is driven only while BUSY is low, rxValid lasts a single cycle and only while BUSY is low, txReady implies an idle undriven bus, a new error leaves BUSY high with the bus released, and the error flag never clears. Other behaviour can only be shown by the bench's scenarios, with a behavioural model compared on every clock. That covers the exact capture latency through the synchronizer, the arbitration between a host edge and a local request, the timeout in each of the three waiting phases, and the fact that a handshake line still high after a timeout does not capture again.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    S_IDLE     = 2'd0,
    S_IN_HOLD  = 2'd1,
    S_OUT_ACK  = 2'd2,
    S_OUT_REL  = 2'd3
  } sbr_state_e;

  typedef struct packed {
    logic captureRx;
    logic loadTx;
    logic driveOn;
    logic driveOff;
    logic cntClr;
    logic setErr;
  } sbr_ctl_t;

endpackage

// File: rtl/sbr_datapath.sv
module sbr_datapath
  import sbr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbr_ctl_t          ctl,
  input  logic [TMO_W-1:0]  tmoLimit,
  input  logic              hostStrobe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic [DATA_W-1:0] txByte,
  output logic              strbLevel,
  output logic              strbRise,
  output logic              tmoExpired,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxByte,
  output logic              errFlag
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   strbLast;
  logic [TMO_W-1:0]       tmoCnt;

  // Synchronizer chain for the asynchronous host line
  always_ff @(posedge clk) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= hostStrobe;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncChain[i] <= 1'b0;
      else       syncChain[i] <= syncChain[i-1];
    end
  end

  assign strbLevel = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) strbLast <= 1'b0;
    else       strbLast <= strbLevel;
  end

  assign strbRise = strbLevel && !strbLast;

  // Phase watchdog, saturating at the limit
  assign tmoExpired = (tmoCnt >= tmoLimit);

  always_ff @(posedge clk) begin
    if (!rstN)            tmoCnt <= '0;
    else if (ctl.cntClr)  tmoCnt <= '0;
    else if (!tmoExpired) tmoCnt <= tmoCnt + 1'b1;
  end

  // Byte registers and bus driver
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte     <= '0;
      rxValid    <= 1'b0;
      busDataOut <= '0;
      busDataOe  <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      rxValid <= ctl.captureRx;
      if (ctl.captureRx) rxByte <= busDataIn;
      if (ctl.loadTx)    busDataOut <= txByte;
      if (ctl.driveOn)       busDataOe <= 1'b1;
      else if (ctl.driveOff) busDataOe <= 1'b0;
      if (ctl.setErr) errFlag <= 1'b1;
    end
  end

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  a_r2_rx_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/sbr_control.sv
module sbr_control
  import sbr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     strbLevel,
  input  logic     strbRise,
  input  logic     tmoExpired,
  input  logic     txValid,
  output sbr_ctl_t ctl,
  output logic     busyOut,
  output logic     txReady
);

  sbr_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (strbRise) begin
          ctl.captureRx = 1'b1;
          ctl.cntClr    = 1'b1;
          stateNext     = S_IN_HOLD;
        end else if (txValid && !strbLevel) begin
          ctl.loadTx  = 1'b1;
          ctl.driveOn = 1'b1;
          ctl.cntClr  = 1'b1;
          stateNext   = S_OUT_ACK;
        end
      end
      S_IN_HOLD: begin
        if (!strbLevel) stateNext = S_IDLE;
        else if (tmoExpired) begin
          ctl.setErr = 1'b1;
          stateNext  = S_IDLE;
        end
      end
      S_OUT_ACK: begin
        if (strbLevel) begin
          ctl.driveOff = 1'b1;
          ctl.cntClr   = 1'b1;
          stateNext    = S_OUT_REL;
        end else if (tmoExpired) begin
          ctl.driveOff = 1'b1;
          ctl.setErr   = 1'b1;
          stateNext    = S_IDLE;
        end
      end
      S_OUT_REL: begin
        if (!strbLevel) stateNext = S_IDLE;
        else if (tmoExpired) begin
          ctl.setErr = 1'b1;
          stateNext  = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busyOut = !((state == S_IN_HOLD) || (state == S_OUT_ACK));
  assign txReady = (state == S_IDLE) && !strbLevel;

endmodule

// File: rtl/strobe_busy_responder.sv
module strobe_busy_responder
  import sbr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TMO_W-1:0]  tmoLimit,
  input  logic              hostStrobe,
  output logic              busyOut,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxByte,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txByte,
  output logic              txReady,
  output logic              errFlag
);

  sbr_ctl_t ctl;
  logic     strbLevel;
  logic     strbRise;
  logic     tmoExpired;

  sbr_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .strbLevel  (strbLevel),
    .strbRise   (strbRise),
    .tmoExpired (tmoExpired),
    .txValid    (txValid),
    .ctl        (ctl),
    .busyOut    (busyOut),
    .txReady    (txReady)
  );

  sbr_datapath #(
    .DATA_W      (DATA_W),
    .TMO_W       (TMO_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .tmoLimit   (tmoLimit),
    .hostStrobe (hostStrobe),
    .busDataIn  (busDataIn),
    .txByte     (txByte),
    .strbLevel  (strbLevel),
    .strbRise   (strbRise),
    .tmoExpired (tmoExpired),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe),
    .rxValid    (rxValid),
    .rxByte     (rxByte),
    .errFlag    (errFlag)
  );

  a_r4_drive_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> !busyOut);

  a_r2_rx_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !busyOut);

  a_r5_ready_is_idle: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (busyOut && !busDataOe));

  a_r7_timeout_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (busyOut && !busDataOe));

endmodule

// File: tb/strobe_busy_responder_tb.sv
module strobe_busy_responder_tb;

  localparam int LIMIT = 30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] tmoLimit = 24'(LIMIT);
  logic        hostStrobe = 1'b0;
  logic        busyOut;
  logic [7:0]  busDataIn = 8'h00;
  logic [7:0]  busDataOut;
  logic        busDataOe;
  logic        rxValid;
  logic [7:0]  rxByte;
  logic        txValid = 1'b0;
  logic [7:0]  txByte = 8'h00;
  logic        txReady;
  logic        errFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] expRx[$];

  always #10 clk = ~clk;

  strobe_busy_responder u_dut (
    .clk(clk), .rstN(rstN), .tmoLimit(tmoLimit), .hostStrobe(hostStrobe),
    .busyOut(busyOut), .busDataIn(busDataIn), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .rxValid(rxValid), .rxByte(rxByte),
    .txValid(txValid), .txByte(txByte), .txReady(txReady), .errFlag(errFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 inbound hold, 2 await ack, 3 await release
  int   mPhase = 0;
  int   mWait = 0;
  bit   mS0 = 0, mS1 = 0, mLast = 0;
  bit   mRxValid = 0, mOe = 0, mErr = 0, mLive = 0;
  logic [7:0] mRxByte = 8'h00, mTxByte = 8'h00;

  always @(posedge clk) begin
    bit rise;
    cycles++;
    if (!rstN) begin
      mPhase = 0; mWait = 0; mS0 = 0; mS1 = 0; mLast = 0;
      mRxValid = 0; mOe = 0; mErr = 0; mRxByte = 0; mTxByte = 0; mLive = 1;
    end else begin
      rise = mS1 && !mLast;
      mRxValid = 0;
      case (mPhase)
        0: if (rise) begin
             mRxByte = busDataIn; mRxValid = 1; mPhase = 1; mWait = 0;
           end else if (txValid && !mS1) begin
             mTxByte = txByte; mOe = 1; mPhase = 2; mWait = 0;
           end
        1: if (!mS1) mPhase = 0;
           else if (mWait >= LIMIT) begin mErr = 1; mPhase = 0; end
           else mWait++;
        2: if (mS1) begin mOe = 0; mPhase = 3; mWait = 0; end
           else if (mWait >= LIMIT) begin mErr = 1; mOe = 0; mPhase = 0; end
           else mWait++;
        default: if (!mS1) mPhase = 0;
           else if (mWait >= LIMIT) begin mErr = 1; mPhase = 0; end
           else mWait++;
      endcase
      mLast = mS1; mS1 = mS0; mS0 = hostStrobe;
    end
  end

  // Per-cycle comparison against the model, plus inbound scoreboard
  always @(negedge clk) begin
    if (mLive) begin
      chk(busyOut == !(mPhase == 1 || mPhase == 2), "R3 busy", busyOut, !(mPhase == 1 || mPhase == 2));
      chk(busDataOe == mOe, "R4 oe", busDataOe, mOe);
      if (mOe) chk(busDataOut == mTxByte, "R4 data", busDataOut, mTxByte);
      chk(rxValid == mRxValid, "R2 rxValid", rxValid, mRxValid);
      chk(txReady == (mPhase == 0 && !mS1), "R5 txReady", txReady, (mPhase == 0 && !mS1));
      chk(errFlag == mErr, "R7 err", errFlag, mErr);
      if (rxValid) begin
        if (expRx.size() == 0) chk(0, "R8 unexpected capture", rxByte, 0);
        else begin
          logic [7:0] e;
          e = expRx.pop_front();
          chk(rxByte == e, "R2 rxByte", rxByte, e);
        end
      end
    end
  end

  task automatic waitBusy(input bit lvl);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (busyOut == lvl) return;
    end
    chk(0, "R3 busy wait", busyOut, lvl);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostSend(input logic [7:0] b);
    @(negedge clk);
    busDataIn = b; hostStrobe = 1'b1; expRx.push_back(b);
    waitBusy(1'b0);
    hostStrobe = 1'b0;
    waitBusy(1'b1);
    idle(3);
  endtask

  task automatic localOffer(input logic [7:0] b);
    for (int i = 0; i < 200 && !txReady; i++) @(negedge clk);
    txValid = 1'b1; txByte = b;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] b);
    waitBusy(1'b0);
    chk(busDataOe && busDataOut == b, "R4 host reads byte", busDataOut, b);
    hostStrobe = 1'b1;
    waitBusy(1'b1);
    chk(!busDataOe, "R5 bus released after ack", busDataOe, 0);
    idle(1);
    chk(!txReady, "R5 not ready while ack high", txReady, 0);
    hostStrobe = 1'b0;
    idle(4);
    chk(txReady, "R5 ready after ack low", txReady, 1);
  endtask

  initial begin : watchdog
    #3000000;
    chk(0, "watchdog", cycles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busyOut && !busDataOe && !rxValid && !errFlag && txReady, "R1 reset state",
        {busyOut, busDataOe, rxValid, errFlag, txReady}, 5'b10001);

    // R2/R3 inbound bytes, latency check on the first
    @(negedge clk);
    busDataIn = 8'hA5; hostStrobe = 1'b1; expRx.push_back(8'hA5);
    idle(2);
    chk(busyOut, "R2 busy still high before third edge", busyOut, 1);
    idle(1);
    chk(!busyOut && rxValid && rxByte == 8'hA5, "R2 capture on third edge", rxByte, 8'hA5);
    hostStrobe = 1'b0;
    waitBusy(1'b1);
    idle(3);
    hostSend(8'h3C);
    hostSend(8'h00);
    hostSend(8'hFF);

    // R4/R5 outbound bytes
    localOffer(8'h5A); hostRead(8'h5A);
    localOffer(8'hC3); hostRead(8'hC3);

    // R6 handshake edge wins over a simultaneous request
    @(negedge clk);
    busDataIn = 8'h96; hostStrobe = 1'b1; expRx.push_back(8'h96);
    idle(2);
    txValid = 1'b1; txByte = 8'h11;
    @(negedge clk);
    txValid = 1'b0;
    chk(!busDataOe && rxByte == 8'h96, "R6 inbound wins", busDataOe, 0);
    // R9 request while busy is ignored
    txValid = 1'b1; txByte = 8'h22;
    @(negedge clk);
    txValid = 1'b0;
    idle(2);
    chk(!busDataOe, "R9 request ignored while busy", busDataOe, 0);
    hostStrobe = 1'b0;
    waitBusy(1'b1);
    idle(4);
    chk(!busDataOe && busyOut, "R9 ignored byte never presented", busDataOe, 0);

    // R7/R8 inbound timeout with the line held high
    @(negedge clk);
    busDataIn = 8'h44; hostStrobe = 1'b1; expRx.push_back(8'h44);
    idle(LIMIT + 10);
    chk(errFlag && busyOut, "R7 inbound timeout", errFlag, 1);
    idle(LIMIT);
    chk(busyOut && !rxValid, "R8 no recapture while line high", busyOut, 1);
    hostStrobe = 1'b0;
    idle(4);

    // R10 flag stays set across normal transfers
    hostSend(8'h81);
    chk(errFlag, "R10 flag sticky", errFlag, 1);

    // R7 outbound ack timeout
    localOffer(8'h77);
    idle(LIMIT + 10);
    chk(!busDataOe && busyOut, "R7 outbound ack timeout", busDataOe, 0);

    // R7 release timeout: ack held high
    localOffer(8'h78);
    waitBusy(1'b0);
    hostStrobe = 1'b1;
    idle(LIMIT + 12);
    chk(busyOut && !busDataOe && errFlag, "R7 release timeout", busyOut, 1);
    hostStrobe = 1'b0;
    idle(4);
    localOffer(8'h79); hostRead(8'h79);
    chk(errFlag, "R10 flag still set", errFlag, 1);
    chk(expRx.size() == 0, "R2 all bytes delivered", expRx.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule